// File: doc/BRIEF.md
# DSSS Dual-Threshold Bit Correlator

This block turns a stream of received spread-spectrum chips back into data bits. Each chip arrives with a strobe. The block compares it against the matching position of a programmable pseudo-noise code and counts the chips that agree. When the last chip of a bit period arrives, it classifies the total. A count at or above the upper limit means a '1'. A count at or below the lower limit means a '0'. A count between the two means the bit cannot be trusted.

A bit period spans either 64 or 32 chips, selected by a mode input. The two 7-bit limits sit in small registers that are written and read through a simple register port. After reset the limits allow eight chip errors on the long code. Raising the tolerance gives more range and immunity to interference, at the cost of less reliable data.

Top module: `dsss_bit_correlator`

## Requirements
- R1: A synchronous active-high reset sets the low limit to 0x08 and the high limit to 0x38. It also clears the chip position and the match count, and drives `bit_valid`, `bit_value` and `bit_invalid` low.
- R2: A write with `reg_wr` high stores `reg_wdata[6:0]` in the low limit when `reg_sel`=0, or in the high limit when `reg_sel`=1. `reg_rdata` always returns the selected limit in bits 6:0, with bit 7 read as 0 whatever was written there.
- R3: The k-th valid chip of a bit period (k counting from 0) counts as a match when `chip_in` equals `pn_code[k]`. The count is the number of matches in the period.
- R4: With `mode_short`=0 a bit period is 64 valid chips. With `mode_short`=1 it is 32 valid chips, and only `pn_code[31:0]` is used.
- R5: A count greater than or equal to the high limit gives `bit_value`=1 and `bit_invalid`=0. This rule takes priority over R6.
- R6: Otherwise, a count less than or equal to the low limit gives `bit_value`=0 and `bit_invalid`=0.
- R7: A count strictly between the limits gives `bit_invalid`=1 and `bit_value`=0. Both flags are 0 whenever `bit_valid` is 0.
- R8: `bit_valid` is a one-cycle pulse in the cycle right after the clock edge that accepts the last chip of a period. Cycles with `chip_valid` low do not advance the period.
- R9: The match count and the chip position restart at every bit boundary, so each bit is judged only on its own chips.
- R10: A newly written limit applies to every bit decided after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_valid | input | 1 | `chip_in` holds a chip this cycle |
| chip_in | input | 1 | Received chip |
| pn_code | input | 64 | Spreading code; bit k is the k-th chip of a period |
| mode_short | input | 1 | 0: 64 chips per bit, 1: 32 chips per bit |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: low limit, 1: high limit |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected limit, bit 7 always 0 |
| bit_valid | output | 1 | Decision pulse |
| bit_value | output | 1 | Recovered bit |
| bit_invalid | output | 1 | Count fell between the limits |

## Verification
The bench drives counts that sit exactly on each limit and one chip past it, in both code lengths. A design with an off-by-one comparison would then call a 56-match '1' undecided, or accept a 55-match one. It also strobes chips with idle cycles in between and sends bits back to back without reset. A counter that advanced on idle cycles or kept the previous total would pulse early or misjudge the second bit. It also programs crossed limits to confirm that '1' wins, and writes bit 7 of a limit register to confirm it reads back as zero.

// File: rtl/dsss_corr_pkg.sv
package dsss_corr_pkg;

    localparam int CODE_LEN  = 64;
    localparam int SHORT_LEN = 32;
    localparam int THR_W     = 7;
    localparam int REG_W     = 8;

    localparam logic [THR_W-1:0] THR_LO_RST = 7'h08;
    localparam logic [THR_W-1:0] THR_HI_RST = 7'h38;

    typedef enum logic {
        LEN_LONG  = 1'b0,
        LEN_SHORT = 1'b1
    } len_mode_e;

    typedef enum logic [1:0] {
        DEC_NONE,
        DEC_ZERO,
        DEC_ONE,
        DEC_UNSURE
    } dec_e;

    typedef struct packed {
        logic valid;
        logic value;
        logic unsure;
    } bit_out_t;

    function automatic bit_out_t to_out(dec_e d);
        bit_out_t o;
        o = '0;
        case (d)
            DEC_ONE:    begin o.valid = 1'b1; o.value = 1'b1; end
            DEC_ZERO:   begin o.valid = 1'b1; end
            DEC_UNSURE: begin o.valid = 1'b1; o.unsure = 1'b1; end
            default:    o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/dsss_thr_regs.sv
module dsss_thr_regs
    import dsss_corr_pkg::*;
#(
    parameter int THR_BITS = THR_W,
    parameter int RD_BITS  = REG_W,
    parameter logic [THR_BITS-1:0] LO_INIT = THR_LO_RST,
    parameter logic [THR_BITS-1:0] HI_INIT = THR_HI_RST
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic                sel,
    input  logic [RD_BITS-1:0]  wdata,
    output logic [RD_BITS-1:0]  rdata,
    output logic [THR_BITS-1:0] thr_lo,
    output logic [THR_BITS-1:0] thr_hi
);
    localparam int NREG = 2;

    logic [THR_BITS-1:0] thr_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [THR_BITS-1:0] INIT = (g == 0) ? LO_INIT : HI_INIT;
        always_ff @(posedge clk) begin
            if (rst)
                thr_q[g] <= INIT;
            else if (wr && (int'(sel) == g))
                thr_q[g] <= wdata[THR_BITS-1:0];
        end
    end

    assign thr_lo = thr_q[0];
    assign thr_hi = thr_q[1];
    assign rdata  = RD_BITS'(sel ? thr_q[1] : thr_q[0]);

endmodule

// File: rtl/dsss_chip_accum.sv
module dsss_chip_accum
    import dsss_corr_pkg::*;
#(
    parameter int LONG_CHIPS  = CODE_LEN,
    parameter int SHORT_CHIPS = SHORT_LEN,
    localparam int IDX_W = $clog2(LONG_CHIPS),
    localparam int CNT_W = $clog2(LONG_CHIPS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  chip_valid,
    input  logic                  chip_in,
    input  logic [LONG_CHIPS-1:0] pn_code,
    input  len_mode_e             mode,
    output logic                  bit_done,
    output logic [CNT_W-1:0]      total
);
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] last_idx;
    logic             match;

    assign last_idx = (mode == LEN_SHORT) ? IDX_W'(SHORT_CHIPS - 1)
                                          : IDX_W'(LONG_CHIPS - 1);
    assign match    = (chip_in == pn_code[idx_q]);
    assign total    = cnt_q + CNT_W'(match);
    assign bit_done = chip_valid && (idx_q >= last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (chip_valid) begin
            if (bit_done) begin
                idx_q <= '0;
                cnt_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
                cnt_q <= total;
            end
        end
    end

endmodule

// File: rtl/dsss_bit_decider.sv
module dsss_bit_decider
    import dsss_corr_pkg::*;
#(
    parameter int CNT_BITS = 7,
    parameter int THR_BITS = THR_W,
    localparam int CMP_W = (CNT_BITS > THR_BITS) ? CNT_BITS : THR_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_done,
    input  logic [CNT_BITS-1:0] total,
    input  logic [THR_BITS-1:0] thr_lo,
    input  logic [THR_BITS-1:0] thr_hi,
    output bit_out_t            out_q
);
    dec_e dec;

    always_comb begin
        if (CMP_W'(total) >= CMP_W'(thr_hi))
            dec = DEC_ONE;
        else if (CMP_W'(total) <= CMP_W'(thr_lo))
            dec = DEC_ZERO;
        else
            dec = DEC_UNSURE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else if (bit_done)
            out_q <= to_out(dec);
        else
            out_q <= '0;
    end

endmodule

// File: rtl/dsss_bit_correlator.sv
module dsss_bit_correlator
    import dsss_corr_pkg::*;
#(
    parameter int LONG_CHIPS  = CODE_LEN,
    parameter int SHORT_CHIPS = SHORT_LEN,
    parameter int THR_BITS    = THR_W,
    parameter int RD_BITS     = REG_W,
    localparam int CNT_W = $clog2(LONG_CHIPS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  chip_valid,
    input  logic                  chip_in,
    input  logic [LONG_CHIPS-1:0] pn_code,
    input  logic                  mode_short,
    input  logic                  reg_wr,
    input  logic                  reg_sel,
    input  logic [RD_BITS-1:0]    reg_wdata,
    output logic [RD_BITS-1:0]    reg_rdata,
    output logic                  bit_valid,
    output logic                  bit_value,
    output logic                  bit_invalid
);
    logic [THR_BITS-1:0] thr_lo;
    logic [THR_BITS-1:0] thr_hi;
    logic                bit_done;
    logic [CNT_W-1:0]    total;
    bit_out_t            dec_q;
    len_mode_e           mode;

    assign mode = mode_short ? LEN_SHORT : LEN_LONG;

    dsss_thr_regs #(
        .THR_BITS (THR_BITS),
        .RD_BITS  (RD_BITS)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .thr_lo (thr_lo),
        .thr_hi (thr_hi)
    );

    dsss_chip_accum #(
        .LONG_CHIPS  (LONG_CHIPS),
        .SHORT_CHIPS (SHORT_CHIPS)
    ) u_accum (
        .clk        (clk),
        .rst        (rst),
        .chip_valid (chip_valid),
        .chip_in    (chip_in),
        .pn_code    (pn_code),
        .mode       (mode),
        .bit_done   (bit_done),
        .total      (total)
    );

    dsss_bit_decider #(
        .CNT_BITS (CNT_W),
        .THR_BITS (THR_BITS)
    ) u_decide (
        .clk      (clk),
        .rst      (rst),
        .bit_done (bit_done),
        .total    (total),
        .thr_lo   (thr_lo),
        .thr_hi   (thr_hi),
        .out_q    (dec_q)
    );

    assign bit_valid   = dec_q.valid;
    assign bit_value   = dec_q.value;
    assign bit_invalid = dec_q.unsure;

endmodule

// File: rtl/dsss_corr_checker.sv
module dsss_corr_checker #(
    parameter int THR_BITS = 7,
    parameter int RD_BITS  = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                chip_valid,
    input logic [RD_BITS-1:0]  reg_rdata,
    input logic                bit_valid,
    input logic                bit_value,
    input logic                bit_invalid,
    input logic [THR_BITS-1:0] thr_lo,
    input logic [THR_BITS-1:0] thr_hi
);
    assert_reset_limits_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (thr_lo == THR_BITS'(8)) && (thr_hi == THR_BITS'(56)) && !bit_valid);

    assert_rdata_msb_zero_R2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[RD_BITS-1] == 1'b0);

    assert_unsure_no_value_R7: assert property (@(posedge clk) disable iff (rst)
        bit_invalid |-> !bit_value);

    assert_flags_need_valid_R7: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |-> !bit_invalid && !bit_value);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);

    assert_pulse_after_chip_R8: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(chip_valid));
endmodule

bind dsss_bit_correlator dsss_corr_checker #(
    .THR_BITS (THR_BITS),
    .RD_BITS  (RD_BITS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .chip_valid  (chip_valid),
    .reg_rdata   (reg_rdata),
    .bit_valid   (bit_valid),
    .bit_value   (bit_value),
    .bit_invalid (bit_invalid),
    .thr_lo      (thr_lo),
    .thr_hi      (thr_hi)
);

// File: tb/sim_dsss_bit_correlator.sv
`timescale 1ns/1ps
module sim_dsss_bit_correlator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_valid = 1'b0;
    logic        chip_in = 1'b0;
    logic [63:0] pn_code = 64'hA5C3_96F0_1E2D_7B48;
    logic        mode_short = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        bit_valid;
    logic        bit_value;
    logic        bit_invalid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dsss_bit_correlator u0 (
        .clk         (clk),
        .rst         (rst),
        .chip_valid  (chip_valid),
        .chip_in     (chip_in),
        .pn_code     (pn_code),
        .mode_short  (mode_short),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .bit_valid   (bit_valid),
        .bit_value   (bit_value),
        .bit_invalid (bit_invalid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic sel, output int val);
        @(negedge clk);
        reg_sel = sel;
        #1 val = int'(reg_rdata);
    endtask

    // Sends one bit of len chips; the first nerr chips are inverted.
    // gap > 0 inserts an idle cycle after every gap-th chip.
    // Returns the decision sampled in the cycle after the last chip, a flag
    // for any pulse seen too early, and a flag for a pulse one cycle too long.
    task automatic send_bit(input logic b, input int nerr, input int len, input int gap,
                            output int v, output int val, output int inv,
                            output int early, output int late);
        early = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (bit_valid) early = 1;
            chip_valid = 1'b1;
            chip_in = (b ? pn_code[i] : ~pn_code[i]) ^ (i < nerr);
            if (gap > 0 && (i % gap) == gap - 1 && i != len - 1) begin
                @(negedge clk);
                if (bit_valid) early = 1;
                chip_valid = 1'b0;
                chip_in = ~chip_in;
            end
        end
        @(negedge clk);
        chip_valid = 1'b0;
        v = int'(bit_valid); val = int'(bit_value); inv = int'(bit_invalid);
        @(negedge clk);
        late = int'(bit_valid);
    endtask

    task automatic expect_bit(input string req, input logic b, input int nerr, input int len,
                              input int gap, input int ev, input int eval, input int einv);
        int v, val, inv, early, late;
        send_bit(b, nerr, len, gap, v, val, inv, early, late);
        check({req, " valid"}, v, ev);
        check({req, " value"}, val, eval);
        check({req, " invalid"}, inv, einv);
        check({req, " no early pulse (R8)"}, early, 0);
        check({req, " single pulse (R8)"}, late, 0);
    endtask

    task automatic t_reset();
        int r;
        do_reset();
        read_reg(1'b0, r); check("R1 low limit default", r, 8);
        read_reg(1'b1, r); check("R1 high limit default", r, 56);
        check("R1 bit_valid low", int'(bit_valid), 0);
        check("R1 bit_invalid low", int'(bit_invalid), 0);
    endtask

    task automatic t_regs();
        int r;
        write_reg(1'b0, 8'hFF);
        read_reg(1'b0, r); check("R2 bit7 dropped low", r, 8'h7F);
        read_reg(1'b1, r); check("R2 other limit kept", r, 56);
        write_reg(1'b1, 8'h95);
        read_reg(1'b1, r); check("R2 bit7 dropped high", r, 8'h15);
        do_reset();
        read_reg(1'b0, r); check("R1 low restored by reset", r, 8);
    endtask

    task automatic t_long();
        mode_short = 1'b0;
        expect_bit("R3 R5 perfect one", 1'b1, 0, 64, 0, 1, 1, 0);
        expect_bit("R3 R6 perfect zero", 1'b0, 0, 64, 0, 1, 0, 0);
        expect_bit("R5 one at limit 56", 1'b1, 8, 64, 0, 1, 1, 0);
        expect_bit("R7 one count 55", 1'b1, 9, 64, 0, 1, 0, 1);
        expect_bit("R6 zero at limit 8", 1'b0, 8, 64, 0, 1, 0, 0);
        expect_bit("R7 zero count 9", 1'b0, 9, 64, 0, 1, 0, 1);
    endtask

    task automatic t_gaps();
        mode_short = 1'b0;
        expect_bit("R8 gapped one", 1'b1, 3, 64, 5, 1, 1, 0);
        expect_bit("R8 gapped zero", 1'b0, 2, 64, 7, 1, 0, 0);
    endtask

    task automatic t_boundary();
        mode_short = 1'b0;
        expect_bit("R9 first bit unsure", 1'b1, 20, 64, 0, 1, 0, 1);
        expect_bit("R9 next bit clean", 1'b1, 0, 64, 0, 1, 1, 0);
        expect_bit("R9 then zero", 1'b0, 0, 64, 0, 1, 0, 0);
    endtask

    task automatic t_short();
        mode_short = 1'b1;
        pn_code[63:32] = 32'h0F0F_F0F0;
        expect_bit("R4 short with long limits", 1'b1, 0, 32, 0, 1, 0, 1);
        write_reg(1'b0, 8'h04);
        write_reg(1'b1, 8'h1C);
        expect_bit("R4 R10 short perfect one", 1'b1, 0, 32, 0, 1, 1, 0);
        expect_bit("R4 R5 short at limit 28", 1'b1, 4, 32, 0, 1, 1, 0);
        expect_bit("R4 R7 short count 27", 1'b1, 5, 32, 0, 1, 0, 1);
        expect_bit("R4 R6 short zero at 4", 1'b0, 4, 32, 3, 1, 0, 0);
        pn_code[63:32] = ~pn_code[63:32];
        expect_bit("R4 upper code ignored", 1'b1, 0, 32, 0, 1, 1, 0);
        mode_short = 1'b0;
        expect_bit("R10 long under new limits", 1'b1, 36, 64, 0, 1, 1, 0);
        do_reset();
    endtask

    task automatic t_overlap();
        mode_short = 1'b0;
        write_reg(1'b0, 8'h40);
        write_reg(1'b1, 8'h10);
        expect_bit("R5 priority over R6", 1'b1, 44, 64, 0, 1, 1, 0);
        expect_bit("R6 below crossed high", 1'b0, 5, 64, 0, 1, 0, 0);
        do_reset();
    endtask

    initial begin
        t_reset();
        t_regs();
        t_long();
        t_gaps();
        t_boundary();
        t_short();
        t_overlap();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule